// File: doc/BRIEF.md
# Random-Root Grouped Pseudo-LRU Victim Selector

This block picks the way to evict from a single 24-way cache set. The ways form three groups of eight. Each group keeps its own 8-way binary-tree pseudo-LRU state. There is no stored root bit. On every miss a pseudo-random generator picks one of the three groups, and that group's tree names the victim inside it.

The cache controller presents one access per cycle. A valid strobe marks the access. A hit flag tells whether it hit. On a hit, a 5-bit way index gives the hit way. On a miss, the block answers in the same cycle with a victim-valid flag and the 5-bit way to fill. The block assumes the fill goes to that way and updates the tree for it. Tags, data arrays, several sets and coherence are handled elsewhere.

Top module: `rr_plru24_sel`

## Requirements
- R1: After reset every tree bit is 0 and the generator holds the seed 16'hACE1. The first miss therefore selects group 1 and returns way 8.
- R2: `victim_valid` is 1 in exactly those cycles where `acc_valid` is 1 and `acc_hit` is 0. It is combinational, in the same cycle as the access.
- R3: The group chosen on a miss is the 16-bit generator value modulo 3. It is never 3. The generator is never zero. It steps once per miss as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R4: The victim equals group×8 plus the leaf reached by walking that group's tree. Node n (1..7, children 2n and 2n+1) goes to child 2n when its bit is 0 and to child 2n+1 when its bit is 1. The leaf is the final node minus 8. Node n's bit is stored at position n−1.
- R5: On a miss, only the selected group's tree changes. Every node on the victim's path is set to point to the other child.
- R6: A hit on a way below 24 updates only the tree of group way/8, in the way R5 describes, for leaf way%8. A hit does not step the generator.
- R7: A hit whose way index is 24 or more leaves all state unchanged.
- R8: In a run of misses with no hits in between, any eight consecutive victims drawn from the same group are eight distinct ways of that group.
- R9: A cycle with `acc_valid` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | The access hit (1) or missed (0) |
| acc_way | input | 5 | Way that hit; ignored on a miss |
| victim_valid | output | 1 | A victim is named this cycle |
| victim_way | output | 5 | Way to fill on this miss |

## Verification
Two things happen in the same miss cycle. The victim is named from the current tree, and that same tree is updated for the fill while the generator steps. Back-to-back misses provoke this, so every clock edge both consumes a victim and rewrites the tree that the next miss may read. The bench keeps its own model of all three trees and of the generator. It predicts each victim exactly, so a fill update that is late, skipped or sent to the wrong group shows up as a wrong way on a later miss. Hits mixed between misses and out-of-range hits then show whether only the intended state moved.

// File: rtl/rr_plru24_pkg.sv
package rr_plru24_pkg;
  localparam int GRP_WAYS  = 8;
  localparam int N_GRPS    = 3;
  localparam int N_WAYS    = GRP_WAYS * N_GRPS;
  localparam int TREE_LVLS = $clog2(GRP_WAYS);
  localparam int NODES     = GRP_WAYS - 1;
  localparam int LEAF_W    = TREE_LVLS;
  localparam int GRP_W     = $clog2(N_GRPS + 1);
  localparam int WAY_W     = $clog2(N_WAYS);
  localparam int RNG_W     = 16;

  typedef logic [NODES-1:0]  tree_t;
  typedef logic [LEAF_W-1:0] leaf_t;

  // walk from the root: bit 0 -> lower child, bit 1 -> upper child
  function automatic leaf_t tree_pick(tree_t b);
    int n;
    n = 1;
    for (int l = 0; l < TREE_LVLS; l++) n = 2 * n + int'(b[n-1]);
    return leaf_t'(n - GRP_WAYS);
  endfunction

  // mark every node on the path to idx as pointing the other way
  function automatic tree_t tree_touch(tree_t b, leaf_t idx);
    tree_t r;
    int    n;
    int    d;
    r = b;
    n = 1;
    for (int l = 0; l < TREE_LVLS; l++) begin
      d = int'(idx[LEAF_W-1-l]);
      r[n-1] = (d == 0);
      n = 2 * n + d;
    end
    return r;
  endfunction

  function automatic logic [RNG_W-1:0] rng_step(logic [RNG_W-1:0] s);
    return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [GRP_W-1:0] rng_to_grp(logic [RNG_W-1:0] s);
    return GRP_W'(s % RNG_W'(N_GRPS));
  endfunction
endpackage

// File: rtl/rr_grp_rng.sv
module rr_grp_rng
  import rr_plru24_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [GRP_W-1:0] grp
);
  logic [RNG_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= rng_step(state_q);
  end

  assign grp = rng_to_grp(state_q);

  assert_rng_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  assert_grp_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grp < GRP_W'(N_GRPS));
  assert_rng_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));
endmodule

// File: rtl/rr_plru8_tree.sv
module rr_plru8_tree
  import rr_plru24_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  touch_en,
  input  leaf_t touch_idx,
  output leaf_t vict_leaf
);
  tree_t bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        bits_q <= '0;
    else if (touch_en) bits_q <= tree_touch(bits_q, touch_idx);
  end

  assign vict_leaf = tree_pick(bits_q);

  assert_touch_away_R5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> vict_leaf != $past(touch_idx));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(bits_q));
endmodule

// File: rtl/rr_plru24_sel.sv
module rr_plru24_sel
  import rr_plru24_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic              miss_ev;
  logic              hit_ok;
  logic [GRP_W-1:0]  grp_sel;
  logic [GRP_W-1:0]  hit_grp;
  leaf_t             sel_leaf;
  leaf_t             vict_leaf [N_GRPS];
  logic [N_GRPS-1:0] touch_vec;

  assign miss_ev = acc_valid && !acc_hit;
  assign hit_ok  = acc_valid && acc_hit && (acc_way < WAY_W'(N_WAYS));
  assign hit_grp = GRP_W'(acc_way / WAY_W'(GRP_WAYS));

  rr_grp_rng #(.SEED(SEED)) u_rng (
    .clk  (clk),
    .rst_n(rst_n),
    .step (miss_ev),
    .grp  (grp_sel)
  );

  for (genvar g = 0; g < N_GRPS; g++) begin : g_grp
    logic  touch;
    leaf_t idx;
    assign touch = (miss_ev && grp_sel == GRP_W'(g)) || (hit_ok && hit_grp == GRP_W'(g));
    assign idx   = miss_ev ? vict_leaf[g] : leaf_t'(acc_way % WAY_W'(GRP_WAYS));
    assign touch_vec[g] = touch;
    rr_plru8_tree u_tree (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch_en (touch),
      .touch_idx(idx),
      .vict_leaf(vict_leaf[g])
    );
  end

  always_comb begin
    sel_leaf = '0;
    for (int g = 0; g < N_GRPS; g++)
      if (grp_sel == GRP_W'(g)) sel_leaf = vict_leaf[g];
  end

  assign victim_valid = miss_ev;
  assign victim_way   = WAY_W'(grp_sel) * WAY_W'(GRP_WAYS) + WAY_W'(sel_leaf);

  assert_one_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(touch_vec));
  assert_victim_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> victim_way < WAY_W'(N_WAYS));
  assert_hit_keeps_grp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_valid |=> $stable(grp_sel));
  assert_bad_hit_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit && acc_way >= WAY_W'(N_WAYS)) |-> touch_vec == '0);
  assert_miss_touches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> $countones(touch_vec) == 1);
endmodule

// File: tb/rr_plru24_sel_test.sv
module rr_plru24_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_hit = 1'b0;
  logic [4:0] acc_way = '0;
  logic       victim_valid;
  logic [4:0] victim_way;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [6:0]  mb [3];
  logic [15:0] mrng;
  logic [7:0]  seen [3];
  int          seen_n [3];
  bit          track = 0;

  always #4 clk = ~clk;

  rr_plru24_sel uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_way(acc_way), .victim_valid(victim_valid), .victim_way(victim_way)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // heap walk with 0-based nodes: children 2i+1 / 2i+2
  function automatic int m_leaf(int g);
    int i = 0;
    while (i < 7) i = 2 * i + 1 + int'(mb[g][i]);
    return i - 7;
  endfunction

  function automatic void m_touch(int g, int leaf);
    int i = 0;
    for (int l = 2; l >= 0; l--) begin
      int d = (leaf >> l) & 1;
      mb[g][i] = (d == 0) ? 1'b1 : 1'b0;
      i = 2 * i + 1 + d;
    end
  endfunction

  function automatic void m_reset();
    for (int g = 0; g < 3; g++) begin
      mb[g] = '0; seen[g] = '0; seen_n[g] = 0;
    end
    mrng = 16'hACE1;
  endfunction

  task automatic access(input bit v, input bit h, input int w, input string req);
    int g;
    int exp_way;
    @(negedge clk);
    acc_valid = v; acc_hit = h; acc_way = 5'(w);
    #2;
    g = int'(mrng) % 3;
    exp_way = g * 8 + m_leaf(g);
    check(victim_valid == (v && !h), "R2", int'(victim_valid), int'(v && !h));
    if (v && !h) begin
      check(int'(victim_way) == exp_way, req, int'(victim_way), exp_way);
      if (track) begin
        int lf = exp_way % 8;
        check(seen[g][lf] == 1'b0, "R8", lf, -1);
        seen[g][lf] = 1'b1;
        seen_n[g]++;
        if (seen_n[g] == 8) begin
          check(seen[g] == 8'hFF, "R8", int'(seen[g]), 255);
          seen[g] = '0; seen_n[g] = 0;
        end
      end
      m_touch(g, exp_way % 8);
      mrng = {mrng[14:0], mrng[15] ^ mrng[13] ^ mrng[12] ^ mrng[10]};
    end else if (v && h && w < 24) begin
      m_touch(w / 8, w % 8);
    end
    @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_valid = 1'b0;
    m_reset();
    @(negedge clk);
    check(victim_valid == 1'b0, "R1", int'(victim_valid), 0);
    rst_n = 1'b1;
    access(1'b1, 1'b0, 0, "R1");
  endtask

  task automatic t_miss_stream();
    track = 1;
    for (int g = 0; g < 3; g++) begin seen[g] = '0; seen_n[g] = 0; end
    for (int k = 0; k < 90; k++) access(1'b1, 1'b0, 0, "R3 R4 R5");
    track = 0;
  endtask

  task automatic t_hits();
    for (int k = 0; k < 24; k++) access(1'b1, 1'b1, (k * 7) % 24, "R6");
    for (int k = 0; k < 12; k++) access(1'b1, 1'b0, 0, "R6");
  endtask

  task automatic t_bad_hit();
    for (int k = 24; k < 32; k++) access(1'b1, 1'b1, k, "R7");
    for (int k = 0; k < 6; k++) access(1'b1, 1'b0, 0, "R7");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 10; k++) access(1'b0, k[0], k, "R9");
    for (int k = 0; k < 6; k++) access(1'b1, 1'b0, 0, "R9");
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 60; k++) begin
      if (k % 3 == 0) access(1'b1, 1'b1, (k * 5) % 24, "R6");
      else access(1'b1, 1'b0, 0, "R4");
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (2) @(posedge clk);
    t_reset();
    t_miss_stream();
    t_hits();
    t_bad_hit();
    t_idle();
    t_mixed();
    t_reset();
    access(1'b1, 1'b0, 0, "R1");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule